// File: doc/BRIEF.md
# Column Burst Buffer Serializer

This block connects the column side of one memory bank to a narrow byte-wide data port. The contents of the open row are held in a local store, which is organised as a set of wide slices. A read request carries a column address. The block copies the whole addressed slice into a read buffer in one step. It then plays the slice out as a burst of byte beats, one beat per cycle, starting at the beat the address names and wrapping around until every beat of the slice has gone out.

A write request works the other way round. The block collects byte beats from the port into a separate write buffer, placing them with the same wrap-around order. Once the last beat has arrived, the block replaces the addressed slice in a single commit cycle and flags completion. A burst of accesses to neighbouring bytes is served from one wide fetch. Any single byte can still be reached by choosing the start beat.

With the default parameters a slice is 128 bits, or 16 beats of 8 bits, and the row holds 64 slices. That gives a 10-bit column address.

Top module: `col_burst_serializer`

## Requirements
- R1: After reset, `rd_valid`, `wr_done` and `busy` are low and every byte of the row store reads back as zero.
- R2: The column address splits into a slice select in bits [9:4] and a start beat in bits [3:0]. Beat number b of a slice is its bits [8b+7:8b].
- R3: After a read request is accepted in idle, `rd_valid` is high for exactly 16 consecutive cycles, starting in the cycle after acceptance.
- R4: Burst beat n of a read (n = 0..15) carries beat (start + n) mod 16 of the selected slice. `rd_data` is zero whenever `rd_valid` is low.
- R5: After a write request is accepted, the k-th cycle with `wr_valid` high stores `wr_data` into beat (start + k) mod 16. Cycles with `wr_valid` low store nothing and do not advance the position.
- R6: The slice changes only after the 16th write beat. `wr_done` is high for exactly one cycle, the cycle after that beat is taken, and the slice holds the new data from the next cycle on. All other slices keep their contents.
- R7: Read requests, write requests and `wr_valid` beats that arrive while `busy` is high are ignored. They neither lengthen a burst nor change the row store.
- R8: When `rd_req` and `wr_req` are both high in idle, the read is accepted and the write is dropped.
- R9: `busy` goes high in the cycle after a request is accepted. It stays high through the read burst, or through write gathering and the commit cycle, and it returns low after that.
- R10: A read issued after a write commit returns the committed data, including for the last slice and the last start beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Start a read burst (taken only in idle) |
| wr_req | input | 1 | Start a write burst (taken only in idle) |
| col_addr | input | 10 | Column address: slice select and start beat |
| wr_valid | input | 1 | A write beat is present on `wr_data` |
| wr_data | input | 8 | Write beat data |
| rd_valid | output | 1 | A read beat is present on `rd_data` |
| rd_data | output | 8 | Read beat data, zero when not valid |
| wr_done | output | 1 | One-cycle pulse when a write slice is committed |
| busy | output | 1 | A burst or commit is in progress |

## Verification
The bench builds the block with its default values: 8-bit beats, 16 beats per slice and 64 slices. This brings the full 4-bit wrap of the start beat within reach, along with the outermost slice, 63. Those values also exercise a row store that is large enough for writes to one slice to be checked against the untouched slices around it. Writes are driven both with continuous beats and with gaps. Stray requests and stray write beats are injected in the middle of bursts, to show that they leave both the outputs and the row untouched.

// File: rtl/bb_pkg.sv
package bb_pkg;

    // Controller phases; a new request is taken only in BB_IDLE
    typedef enum logic [1:0] {
        BB_IDLE    = 2'd0,
        BB_READ    = 2'd1,
        BB_GATHER  = 2'd2,
        BB_COMMIT  = 2'd3
    } bb_state_t;

endpackage

// File: rtl/bb_col_split.sv
// Splits a column address into the slice select (upper bits)
// and the first beat of the burst (lower bits).
module bb_col_split #(
    parameter int SEL_W = 6,
    parameter int IDX_W = 4
) (
    input  logic [SEL_W+IDX_W-1:0] col_addr,
    output logic [SEL_W-1:0]       slice_sel,
    output logic [IDX_W-1:0]       start_beat
);

    assign slice_sel  = col_addr[SEL_W+IDX_W-1:IDX_W];
    assign start_beat = col_addr[IDX_W-1:0];

endmodule

// File: rtl/bb_row_store.sv
// Open-row model held as an array of wide slices: one combinational
// fetch port, one registered slice-wide commit port.
module bb_row_store #(
    parameter int SLICES  = 64,
    parameter int SLICE_W = 128,
    localparam int SEL_W  = $clog2(SLICES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_en,
    input  logic [SEL_W-1:0]   commit_sel,
    input  logic [SLICE_W-1:0] commit_data,
    input  logic [SEL_W-1:0]   fetch_sel,
    output logic [SLICE_W-1:0] fetch_data
);

    logic [SLICE_W-1:0] slot_q [SLICES];

    for (genvar s = 0; s < SLICES; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (commit_en && (commit_sel == SEL_W'(s))) begin
                slot_q[s] <= commit_data;
            end
        end
    end

    assign fetch_data = slot_q[fetch_sel];

endmodule

// File: rtl/bb_beat_mux.sv
// Picks one beat out of a buffered slice.
module bb_beat_mux #(
    parameter int BEAT_W  = 8,
    parameter int BEATS   = 16,
    localparam int IDX_W  = $clog2(BEATS),
    localparam int SLICE_W = BEAT_W * BEATS
) (
    input  logic [SLICE_W-1:0] slice_in,
    input  logic [IDX_W-1:0]   beat_idx,
    output logic [BEAT_W-1:0]  beat_out
);

    logic [BEAT_W-1:0] lane [BEATS];

    for (genvar b = 0; b < BEATS; b++) begin : g_lane
        assign lane[b] = slice_in[b*BEAT_W +: BEAT_W];
    end

    assign beat_out = lane[beat_idx];

endmodule

// File: rtl/bb_burst_ctrl.sv
// Burst sequencer: captures a slice for reads, gathers beats for
// writes, walks the beat index with wrap-around, drives the commit.
module bb_burst_ctrl
    import bb_pkg::*;
#(
    parameter int BEAT_W   = 8,
    parameter int BEATS    = 16,
    parameter int SLICES   = 64,
    localparam int IDX_W   = $clog2(BEATS),
    localparam int SEL_W   = $clog2(SLICES),
    localparam int SLICE_W = BEAT_W * BEATS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  logic               wr_req,
    input  logic [SEL_W-1:0]   req_sel,
    input  logic [IDX_W-1:0]   req_beat,
    input  logic               wr_valid,
    input  logic [BEAT_W-1:0]  wr_data,
    input  logic [SLICE_W-1:0] fetch_data,
    output logic               burst_active,
    output logic [IDX_W-1:0]   beat_idx,
    output logic [SLICE_W-1:0] read_buf,
    output logic               commit_en,
    output logic [SEL_W-1:0]   commit_sel,
    output logic [SLICE_W-1:0] commit_data,
    output logic               busy
);

    localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(BEATS - 1);

    typedef struct packed {
        bb_state_t          st;
        logic [SEL_W-1:0]   sel;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   cnt;
        logic [SLICE_W-1:0] rbuf;
        logic [SLICE_W-1:0] wbuf;
    } ctrl_t;

    ctrl_t ctl_q, ctl_d;

    logic [IDX_W-1:0] idx_next;

    // Wrapping beat successor; explicit so non-power-of-two counts wrap too
    assign idx_next = (ctl_q.idx == LAST_BEAT) ? '0 : ctl_q.idx + 1'b1;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            BB_IDLE: begin
                if (rd_req) begin
                    ctl_d.st   = BB_READ;
                    ctl_d.sel  = req_sel;
                    ctl_d.idx  = req_beat;
                    ctl_d.cnt  = '0;
                    ctl_d.rbuf = fetch_data;
                end else if (wr_req) begin
                    ctl_d.st   = BB_GATHER;
                    ctl_d.sel  = req_sel;
                    ctl_d.idx  = req_beat;
                    ctl_d.cnt  = '0;
                end
            end
            BB_READ: begin
                ctl_d.idx = idx_next;
                ctl_d.cnt = ctl_q.cnt + 1'b1;
                if (ctl_q.cnt == LAST_BEAT) begin
                    ctl_d.st = BB_IDLE;
                end
            end
            BB_GATHER: begin
                if (wr_valid) begin
                    for (int b = 0; b < BEATS; b++) begin
                        if (ctl_q.idx == IDX_W'(b)) begin
                            ctl_d.wbuf[b*BEAT_W +: BEAT_W] = wr_data;
                        end
                    end
                    ctl_d.idx = idx_next;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_BEAT) begin
                        ctl_d.st = BB_COMMIT;
                    end
                end
            end
            BB_COMMIT: begin
                ctl_d.st = BB_IDLE;
            end
            default: begin
                ctl_d.st = BB_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign burst_active = (ctl_q.st == BB_READ);
    assign beat_idx     = ctl_q.idx;
    assign read_buf     = ctl_q.rbuf;
    assign commit_en    = (ctl_q.st == BB_COMMIT);
    assign commit_sel   = ctl_q.sel;
    assign commit_data  = ctl_q.wbuf;
    assign busy         = (ctl_q.st != BB_IDLE);

endmodule

// File: rtl/col_burst_serializer.sv
module col_burst_serializer #(
    parameter int BEAT_W   = 8,
    parameter int BEATS    = 16,
    parameter int SLICES   = 64,
    localparam int IDX_W   = $clog2(BEATS),
    localparam int SEL_W   = $clog2(SLICES),
    localparam int COL_W   = SEL_W + IDX_W,
    localparam int SLICE_W = BEAT_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [COL_W-1:0]  col_addr,
    input  logic              wr_valid,
    input  logic [BEAT_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [BEAT_W-1:0] rd_data,
    output logic              wr_done,
    output logic              busy
);

    logic [SEL_W-1:0]   req_sel;
    logic [IDX_W-1:0]   req_beat;
    logic [SLICE_W-1:0] fetch_data;
    logic               burst_active;
    logic [IDX_W-1:0]   beat_idx;
    logic [SLICE_W-1:0] read_buf;
    logic               commit_en;
    logic [SEL_W-1:0]   commit_sel;
    logic [SLICE_W-1:0] commit_data;
    logic [BEAT_W-1:0]  beat_val;

    bb_col_split #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_split (
        .col_addr   (col_addr),
        .slice_sel  (req_sel),
        .start_beat (req_beat)
    );

    bb_row_store #(.SLICES(SLICES), .SLICE_W(SLICE_W)) u_row (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_en   (commit_en),
        .commit_sel  (commit_sel),
        .commit_data (commit_data),
        .fetch_sel   (req_sel),
        .fetch_data  (fetch_data)
    );

    bb_burst_ctrl #(.BEAT_W(BEAT_W), .BEATS(BEATS), .SLICES(SLICES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req       (rd_req),
        .wr_req       (wr_req),
        .req_sel      (req_sel),
        .req_beat     (req_beat),
        .wr_valid     (wr_valid),
        .wr_data      (wr_data),
        .fetch_data   (fetch_data),
        .burst_active (burst_active),
        .beat_idx     (beat_idx),
        .read_buf     (read_buf),
        .commit_en    (commit_en),
        .commit_sel   (commit_sel),
        .commit_data  (commit_data),
        .busy         (busy)
    );

    bb_beat_mux #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_mux (
        .slice_in (read_buf),
        .beat_idx (beat_idx),
        .beat_out (beat_val)
    );

    assign rd_valid = burst_active;
    assign rd_data  = burst_active ? beat_val : '0;
    assign wr_done  = commit_en;

endmodule

// File: rtl/bb_chk.sv
module bb_chk #(
    parameter int BEATS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic wr_req,
    input logic wr_valid,
    input logic rd_valid,
    input logic wr_done,
    input logic busy
);

    localparam int RUN_W = $clog2(BEATS) + 1;

    // Length of the current run of valid read beats
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (rd_valid) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R3
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(rd_req && !busy));

    // R3
    burst_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (run_q < RUN_W'(BEATS)));

    // R3
    burst_len_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_valid) |-> (run_q == RUN_W'(BEATS)));

    // R6
    done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_done) |-> $past(wr_valid && busy));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    // R8
    read_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req && !busy) |=> rd_valid);

    // R9
    busy_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req || wr_req) && !busy) |=> busy);

    // R9
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_done) |-> busy);

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_done));

endmodule

bind col_burst_serializer bb_chk #(.BEATS(BEATS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .wr_valid (wr_valid),
    .rd_valid (rd_valid),
    .wr_done  (wr_done),
    .busy     (busy)
);

// File: tb/tb_col_burst_serializer.sv
`timescale 1ns/1ps
module tb_col_burst_serializer;

    localparam int BW    = 8;
    localparam int NB    = 16;
    localparam int NS    = 64;
    localparam int COLW  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rd_req = 1'b0;
    logic            wr_req = 1'b0;
    logic [COLW-1:0] col_addr = '0;
    logic            wr_valid = 1'b0;
    logic [BW-1:0]   wr_data = '0;
    logic            rd_valid;
    logic [BW-1:0]   rd_data;
    logic            wr_done;
    logic            busy;

    int n_chk = 0;
    int n_err = 0;
    bit live = 1'b0;

    always #2 clk = ~clk;

    col_burst_serializer dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .col_addr(col_addr), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done), .busy(busy)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_row  [NS*NB];
    logic [7:0] m_rbuf [NB];
    logic [7:0] m_wbuf [NB];
    int m_mode = 0;   // 0 idle, 1 read, 2 gather, 3 commit
    int m_sel = 0, m_idx = 0, m_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_idx = 0; m_sel = 0;
            for (int i = 0; i < NS*NB; i++) m_row[i] = 8'h00;
        end else begin
            case (m_mode)
                0: begin
                    if (rd_req) begin
                        m_mode = 1; m_sel = int'(col_addr) / NB;
                        m_idx = int'(col_addr) % NB; m_cnt = 0;
                        for (int i = 0; i < NB; i++) m_rbuf[i] = m_row[m_sel*NB + i];
                    end else if (wr_req) begin
                        m_mode = 2; m_sel = int'(col_addr) / NB;
                        m_idx = int'(col_addr) % NB; m_cnt = 0;
                    end
                end
                1: begin
                    m_idx = (m_idx + 1) % NB; m_cnt++;
                    if (m_cnt == NB) m_mode = 0;
                end
                2: begin
                    if (wr_valid) begin
                        m_wbuf[m_idx] = wr_data;
                        m_idx = (m_idx + 1) % NB; m_cnt++;
                        if (m_cnt == NB) m_mode = 3;
                    end
                end
                default: begin
                    for (int i = 0; i < NB; i++) m_row[m_sel*NB + i] = m_wbuf[i];
                    m_mode = 0;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk("R3 rd_valid per cycle", 32'(rd_valid), 32'(m_mode == 1));
            chk("R4 rd_data per cycle", 32'(rd_data), (m_mode == 1) ? 32'(m_rbuf[m_idx]) : 32'h0);
            chk("R6 wr_done per cycle", 32'(wr_done), 32'(m_mode == 3));
            chk("R9 busy per cycle", 32'(busy), 32'(m_mode != 0));
        end
    end

    function automatic logic [7:0] pat(input int sel, input int pos, input int seed);
        return 8'((sel * 37 + pos * 11 + seed * 5 + 1) & 8'hff);
    endfunction

    // Read burst with directed checks. mode: 0 plain, 1 stray inputs
    // mid-burst (R7), 2 rd_req and wr_req together (R8)
    task automatic rd_burst(input int sel, input int start, input int mode);
        logic [7:0] exp_b [NB];
        @(negedge clk);
        for (int i = 0; i < NB; i++) exp_b[i] = m_row[sel*NB + i];
        col_addr = COLW'(sel * NB + start);
        rd_req = 1'b1;
        wr_req = (mode == 2);
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        for (int n = 0; n < NB; n++) begin
            if (mode == 1 && n == 4) begin rd_req = 1'b1; wr_req = 1'b1; end
            if (mode == 1) begin wr_valid = 1'b1; wr_data = 8'hA5; end
            if (n == 0) chk("R2 first beat from start position", 32'(rd_data), 32'(exp_b[start]));
            chk("R3 burst valid", 32'(rd_valid), 32'h1);
            chk("R4 wrapped beat", 32'(rd_data), 32'(exp_b[(start + n) % NB]));
            if (mode == 2) chk("R8 read wins", 32'(rd_valid), 32'h1);
            @(negedge clk);
            rd_req = 1'b0; wr_req = 1'b0;
        end
        wr_valid = 1'b0;
        chk("R3 burst ends after 16", 32'(rd_valid), 32'h0);
        chk("R7 stray requests not extending", 32'(busy), 32'h0);
    endtask

    // Write burst; gaps inserts idle cycles between beats (R5),
    // poke drives stray requests during gathering (R7)
    task automatic wr_burst(input int sel, input int start, input int seed,
                            input bit gaps, input bit poke);
        @(negedge clk);
        col_addr = COLW'(sel * NB + start);
        wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        for (int n = 0; n < NB; n++) begin
            if (gaps && (n % 3 == 1)) begin
                wr_valid = 1'b0;
                wr_data = 8'hEE;
                @(negedge clk);
            end
            wr_valid = 1'b1;
            wr_data = pat(sel, (start + n) % NB, seed);
            if (poke && n == 5) begin rd_req = 1'b1; wr_req = 1'b1; end
            @(negedge clk);
            rd_req = 1'b0; wr_req = 1'b0;
            if (n < NB - 1) chk("R6 no done before last beat", 32'(wr_done), 32'h0);
        end
        wr_valid = 1'b0;
        chk("R6 done pulse after 16th beat", 32'(wr_done), 32'h1);
        @(negedge clk);
        chk("R6 done is one cycle", 32'(wr_done), 32'h0);
        chk("R9 busy clears after commit", 32'(busy), 32'h0);
    endtask

    // Independent expectation from the write pattern
    task automatic expect_slice(input int sel, input int seed, input string tag);
        for (int p = 0; p < NB; p++)
            chk(tag, 32'(m_row[sel*NB + p]), 32'(pat(sel, p, seed)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_valid after reset", 32'(rd_valid), 32'h0);
        chk("R1 wr_done after reset", 32'(wr_done), 32'h0);
        chk("R1 busy after reset", 32'(busy), 32'h0);
        chk("R1 rd_data after reset", 32'(rd_data), 32'h0);
        rd_burst(0, 0, 0);              // R1 zero row
        rd_burst(63, 15, 0);            // R1 zero row, top slice
        // R5 R6 continuous write, then read back (R10)
        wr_burst(5, 0, 1, 1'b0, 1'b0);
        expect_slice(5, 1, "R10 model matches pattern slice 5");
        rd_burst(5, 3, 0);
        rd_burst(4, 0, 0);              // R6 neighbour untouched
        rd_burst(6, 7, 0);              // R6 neighbour untouched
        // R5 gapped write with wrapped start, stray requests (R7)
        wr_burst(9, 11, 2, 1'b1, 1'b1);
        expect_slice(9, 2, "R5 gapped write placement slice 9");
        rd_burst(9, 11, 0);
        rd_burst(9, 0, 1);              // R7 stray inputs during read
        rd_burst(9, 6, 0);              // R7 slice unchanged
        // R8 simultaneous requests
        rd_burst(5, 15, 2);
        rd_burst(5, 1, 0);              // R8 dropped write left slice alone
        // R10 boundary slice and beat
        wr_burst(63, 15, 3, 1'b1, 1'b0);
        rd_burst(63, 15, 0);
        rd_burst(62, 2, 0);
        // back-to-back overwrite of the same slice
        wr_burst(5, 8, 4, 1'b0, 1'b0);
        expect_slice(5, 4, "R10 overwrite slice 5");
        rd_burst(5, 12, 0);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule